// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block picks the hardware thread that may fetch in the current cycle. Each thread has an active bit, a fetch-state code and two occupancy counts: one for its issue queue and one for its load/store queue. A policy input chooses how the winner is found. The options are a fixed single-thread choice, a move-to-back round-robin order, or the thread with the lowest issue-queue or load/store-queue occupancy. The result is combinational. It is a valid flag and a thread index.

The round-robin order is a stored priority list, not a rotating pointer. The list is scanned from its head. When the consumer takes a round-robin grant with the take strobe, the granted thread moves to the tail. A thread whose active bit is low is dropped from the list. A thread that becomes active again is placed at the tail. The occupancy counts are produced elsewhere.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is a candidate only when its active bit is 1 and its fetch-state code is 0 (running), 1 (idle) or 7 (cache fill done). Codes 2 to 6 never make a thread a candidate.
- R2: With policy code 0 (single thread), thread 0 is selected when it is a candidate. Otherwise `sel_valid` is 0, whatever the other threads do.
- R3: With policy code 1 (round-robin), the selection is the first candidate found when scanning the priority list from its head.
- R4: A rising clock edge with `grant_take` high, policy code 1 and `sel_valid` high moves the selected thread to the tail of the list. The relative order of the other threads is kept.
- R5: With policy code 2, the candidate with the smallest `iq_occ` is selected. On equal occupancy the lower thread index wins.
- R6: With policy code 3, the candidate with the smallest `lsq_occ` is selected. On equal occupancy the lower thread index wins.
- R7: When there is no candidate, `sel_valid` is 0 and `sel_thread` is 0 under every policy.
- R8: After reset, the list holds all threads in ascending index order, thread 0 at the head.
- R9: At each clock edge, a thread whose active bit is 0 leaves the list. A thread that is active but not in the list is appended at the tail, lower indices first.
- R10: Policy codes 4 to 7 give `sel_valid` = 0 and `sel_thread` = 0.
- R11: `grant_take` under policy codes 0, 2 and 3 leaves the list order unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NUM_THREADS | Per-thread active mask |
| fetch_state | input | NUM_THREADS x 3 | Per-thread fetch-state code |
| iq_occ | input | NUM_THREADS x OCC_W | Per-thread issue-queue occupancy |
| lsq_occ | input | NUM_THREADS x OCC_W | Per-thread load/store-queue occupancy |
| policy | input | 3 | Selection policy code |
| grant_take | input | 1 | Consumer takes the current grant |
| sel_valid | output | 1 | A thread is selected |
| sel_thread | output | log2(NUM_THREADS) | Index of the selected thread |

## Verification
All eight state codes are applied to a lone thread. This separates the fetchable codes from the stalled ones.

Several round-robin sequences are run:
- repeated takes, which show move-to-back behaviour rather than a rotating pointer;
- a thread dropped and later re-activated, which shows removal and tail insertion;
- takes issued under the other policies, which must leave the order untouched.

Occupancy patterns with distinct values, full ties and partial ties tell the minimum search apart from index priority, and show which queue each policy reads. A long random run then mixes states, masks, policies and takes. It is compared against a reference list kept by the bench, which exposes stale-order or wrong-candidate errors that the directed cases miss.

// File: rtl/fts_pkg.sv
package fts_pkg;

  localparam int STATE_W  = 3;
  localparam int POLICY_W = 3;

  typedef enum logic [STATE_W-1:0] {
    FS_RUN        = 3'd0,
    FS_IDLE       = 3'd1,
    FS_SQUASH     = 3'd2,
    FS_BLOCKED    = 3'd3,
    FS_XLATE_WAIT = 3'd4,
    FS_MISS_WAIT  = 3'd5,
    FS_RETRY_WAIT = 3'd6,
    FS_FILL_DONE  = 3'd7
  } fetch_state_e;

  typedef enum logic [POLICY_W-1:0] {
    POL_SINGLE = 3'd0,
    POL_RR     = 3'd1,
    POL_IQ     = 3'd2,
    POL_LSQ    = 3'd3
  } policy_e;

  function automatic logic state_fetchable(input logic [STATE_W-1:0] st);
    return (st == FS_RUN) || (st == FS_IDLE) || (st == FS_FILL_DONE);
  endfunction

endpackage

// File: rtl/fts_eligibility.sv
module fts_eligibility
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0]              active,
  input  logic [NUM_THREADS-1:0][STATE_W-1:0] state,
  output logic [NUM_THREADS-1:0]              cand
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign cand[t] = active[t] & state_fetchable(state[t]);
  end
endmodule

// File: rtl/fts_occ_pick.sv
module fts_occ_pick #(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 6,
  localparam int IDW        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic [NUM_THREADS-1:0]            cand,
  input  logic [NUM_THREADS-1:0][OCC_W-1:0] occ,
  output logic                              valid,
  output logic [IDW-1:0]                    idx
);
  // Strict less-than keeps the earlier (lower) index on a tie.
  function automatic logic beats(input logic have, input logic [OCC_W-1:0] a,
                                 input logic [OCC_W-1:0] b);
    return !have || (a < b);
  endfunction

  logic [OCC_W-1:0] best_occ;

  always_comb begin
    valid    = 1'b0;
    idx      = '0;
    best_occ = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (cand[t] && beats(valid, occ[t], best_occ)) begin
        valid    = 1'b1;
        idx      = IDW'(t);
        best_occ = occ[t];
      end
    end
  end
endmodule

// File: rtl/fts_prio_list.sv
module fts_prio_list #(
  parameter int NUM_THREADS = 4,
  localparam int IDW        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CW         = $clog2(NUM_THREADS + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS-1:0]        active,
  input  logic                          move_req,
  input  logic [IDW-1:0]                move_id,
  output logic [NUM_THREADS-1:0][IDW-1:0] order,
  output logic [CW-1:0]                 len,
  output logic [NUM_THREADS-1:0]        present,
  output logic [IDW-1:0]                tail
);
  // One spare slot at index NUM_THREADS keeps every shift and tail read in range.
  logic [IDW-1:0] slot_q [0:NUM_THREADS];
  logic [IDW-1:0] slot_d [0:NUM_THREADS];
  logic [CW-1:0]  len_q, len_d;

  function automatic logic in_list(input int pos, input logic [CW-1:0] n);
    return CW'(pos) < n;
  endfunction

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      present[t] = 1'b0;
      for (int k = 0; k < NUM_THREADS; k++)
        if (in_list(k, len_q) && slot_q[k] == IDW'(t)) present[t] = 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_THREADS; k++) begin : g_ord
    assign order[k] = slot_q[k];
  end
  assign len  = len_q;
  assign tail = (len_q == '0) ? '0 : slot_q[len_q - CW'(1)];

  logic found;
  always_comb begin
    for (int k = 0; k <= NUM_THREADS; k++) slot_d[k] = '0;
    len_d = '0;
    found = 1'b0;
    // step 1: drop inactive threads, keep order
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (in_list(k, len_q) && active[slot_q[k]]) begin
        slot_d[len_d] = slot_q[k];
        len_d = len_d + CW'(1);
      end
    end
    // step 2: move the granted thread to the tail
    if (move_req) begin
      for (int k = 0; k < NUM_THREADS; k++) begin
        if (in_list(k, len_d)) begin
          if (!found && slot_d[k] == move_id) found = 1'b1;
          if (found) slot_d[k] = slot_d[k+1];
        end
      end
      if (found) slot_d[len_d - CW'(1)] = move_id;
    end
    // step 3: append newly active threads
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (active[t] && !present[t]) begin
        slot_d[len_d] = IDW'(t);
        len_d = len_d + CW'(1);
      end
    end
    slot_d[NUM_THREADS] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_THREADS; k++) slot_q[k] <= IDW'(k);
      slot_q[NUM_THREADS] <= '0;
      len_q <= CW'(NUM_THREADS);
    end else begin
      for (int k = 0; k <= NUM_THREADS; k++) slot_q[k] <= slot_d[k];
      len_q <= len_d;
    end
  end
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel
  import fts_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int OCC_W       = 6,
  localparam int IDW        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int CW         = $clog2(NUM_THREADS + 1)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_THREADS-1:0]              thread_active,
  input  logic [NUM_THREADS-1:0][STATE_W-1:0] fetch_state,
  input  logic [NUM_THREADS-1:0][OCC_W-1:0]   iq_occ,
  input  logic [NUM_THREADS-1:0][OCC_W-1:0]   lsq_occ,
  input  logic [POLICY_W-1:0]                 policy,
  input  logic                                grant_take,
  output logic                                sel_valid,
  output logic [IDW-1:0]                      sel_thread
);
  logic [NUM_THREADS-1:0]          elig_vec;
  logic [NUM_THREADS-1:0][IDW-1:0] list_order;
  logic [CW-1:0]                   list_len;
  logic [NUM_THREADS-1:0]          list_present;
  logic [IDW-1:0]                  list_tail;
  logic                            iq_valid, lsq_valid, rr_valid;
  logic [IDW-1:0]                  iq_idx, lsq_idx, rr_idx;
  logic                            rr_move;

  fts_eligibility #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .active(thread_active), .state(fetch_state), .cand(elig_vec));

  fts_occ_pick #(.NUM_THREADS(NUM_THREADS), .OCC_W(OCC_W)) u_pick_iq (
    .cand(elig_vec), .occ(iq_occ), .valid(iq_valid), .idx(iq_idx));

  fts_occ_pick #(.NUM_THREADS(NUM_THREADS), .OCC_W(OCC_W)) u_pick_lsq (
    .cand(elig_vec), .occ(lsq_occ), .valid(lsq_valid), .idx(lsq_idx));

  fts_prio_list #(.NUM_THREADS(NUM_THREADS)) u_list (
    .clk(clk), .rst_n(rst_n), .active(thread_active),
    .move_req(rr_move), .move_id(sel_thread),
    .order(list_order), .len(list_len), .present(list_present),
    .tail(list_tail));

  // Round-robin scan from the list head.
  always_comb begin
    rr_valid = 1'b0;
    rr_idx   = '0;
    for (int k = 0; k < NUM_THREADS; k++) begin
      if (!rr_valid && (CW'(k) < list_len) && elig_vec[list_order[k]]) begin
        rr_valid = 1'b1;
        rr_idx   = list_order[k];
      end
    end
  end

  always_comb begin
    sel_valid  = 1'b0;
    sel_thread = '0;
    case (policy)
      POL_SINGLE: sel_valid = elig_vec[0];
      POL_RR:     begin sel_valid = rr_valid;  sel_thread = rr_idx;  end
      POL_IQ:     begin sel_valid = iq_valid;  sel_thread = iq_idx;  end
      POL_LSQ:    begin sel_valid = lsq_valid; sel_thread = lsq_idx; end
      default:    ;
    endcase
  end

  assign rr_move = grant_take && sel_valid && (policy == POL_RR);
endmodule

// File: rtl/fetch_thread_sel_chk.sv
module fetch_thread_sel_chk #(
  parameter int NUM_THREADS = 4,
  parameter int IDW         = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2:0]             policy,
  input logic                   sel_valid,
  input logic [IDW-1:0]         sel_thread,
  input logic [NUM_THREADS-1:0] elig_vec,
  input logic [NUM_THREADS-1:0] thread_active,
  input logic [NUM_THREADS-1:0] list_present,
  input logic [IDW-1:0]         list_tail,
  input logic                   rr_move
);
  p_pick_is_cand_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> elig_vec[sel_thread]);

  p_single_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (policy == 3'd0 && sel_valid) |-> sel_thread == '0);

  p_move_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rr_move && ((thread_active & ~list_present) == '0)) |=> list_tail == $past(sel_thread));

  p_none_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (elig_vec == '0) |-> !sel_valid);

  p_inactive_gone_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!thread_active[0]) |=> !list_present[0]);

  p_bad_policy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (policy[2]) |-> (!sel_valid && sel_thread == '0));
endmodule

bind fetch_thread_sel fetch_thread_sel_chk #(.NUM_THREADS(NUM_THREADS), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .policy(policy), .sel_valid(sel_valid),
  .sel_thread(sel_thread), .elig_vec(elig_vec), .thread_active(thread_active),
  .list_present(list_present), .list_tail(list_tail), .rr_move(rr_move));

// File: tb/fetch_thread_sel_tb.sv
module fetch_thread_sel_tb;
  localparam int N  = 4;
  localparam int OW = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] act;
  logic [N-1:0][2:0] st;
  logic [N-1:0][OW-1:0] iq, lsq;
  logic [2:0] pol;
  logic take;
  logic sv;
  logic [1:0] sth;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_list[N];
  int m_len;

  always #4 clk = ~clk;

  fetch_thread_sel #(.NUM_THREADS(N), .OCC_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .thread_active(act), .fetch_state(st),
    .iq_occ(iq), .lsq_occ(lsq), .policy(pol), .grant_take(take),
    .sel_valid(sv), .sel_thread(sth));

  function automatic bit cand(int t);
    return act[t] && (st[t] == 3'd0 || st[t] == 3'd1 || st[t] == 3'd7);
  endfunction

  // expected {valid, index}; index is -1 when invalid
  function automatic int exp_sel();
    case (pol)
      3'd0: return cand(0) ? 0 : -1;
      3'd1: begin
        for (int k = 0; k < m_len; k++) if (cand(m_list[k])) return m_list[k];
        return -1;
      end
      3'd2, 3'd3: begin
        for (int v = 0; v < (1 << OW); v++)
          for (int t = 0; t < N; t++)
            if (cand(t) && ((pol == 3'd2) ? iq[t] : lsq[t]) == v) return t;
        return -1;
      end
      default: return -1;
    endcase
  endfunction

  task automatic model_update(int e);
    int nl[N];
    int n = 0;
    bit inl;
    for (int k = 0; k < m_len; k++) if (act[m_list[k]]) begin nl[n] = m_list[k]; n++; end
    if (take && pol == 3'd1 && e >= 0) begin
      int p = -1;
      for (int k = 0; k < n; k++) if (nl[k] == e && p < 0) p = k;
      if (p >= 0) begin
        for (int k = p; k < n - 1; k++) nl[k] = nl[k+1];
        nl[n-1] = e;
      end
    end
    for (int t = 0; t < N; t++) begin
      inl = 0;
      for (int k = 0; k < m_len; k++) if (m_list[k] == t) inl = 1;
      if (act[t] && !inl) begin nl[n] = t; n++; end
    end
    m_list = nl;
    m_len  = n;
  endtask

  // inputs already driven after a negedge; check, then cross the edge
  task automatic step(string req);
    int e;
    #1;
    e = exp_sel();
    checks++;
    if ((e < 0 && (sv !== 1'b0 || sth !== 2'd0)) ||
        (e >= 0 && (sv !== 1'b1 || sth !== e[1:0]))) begin
      errors++;
      $display("FAIL %s: got valid=%0b thread=%0d, expected valid=%0b thread=%0d",
               req, sv, sth, e >= 0, (e < 0) ? 0 : e);
    end
    model_update(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic all_run();
    act = '1; for (int t = 0; t < N; t++) st[t] = 3'd0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; act = '1; st = '0; iq = '0; lsq = '0; pol = 3'd1; take = 1'b0;
    for (int k = 0; k < N; k++) m_list[k] = k;
    m_len = N;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R8 / R3 / R4: reset order visible through successive round-robin takes
    all_run(); pol = 3'd1; take = 1'b1;
    for (int i = 0; i < 6; i++) step("R8_R4");
    take = 1'b0;
    // R3: head is ineligible, next in list wins
    st[2] = 3'd3; step("R3");
    all_run();

    // R1: each state code on a lone thread under single policy
    act = 4'b0001; pol = 3'd0;
    for (int c = 0; c < 8; c++) begin st[0] = 3'(c); step("R1"); end
    // R2: thread 0 inactive, others fine -> invalid
    all_run(); act = 4'b1110; step("R2");
    all_run(); st[0] = 3'd5; step("R2");

    // R7: nothing eligible, every policy
    all_run(); for (int t = 0; t < N; t++) st[t] = 3'd4;
    for (int p = 0; p < 4; p++) begin pol = 3'(p); step("R7"); end
    // R10: unsupported codes
    all_run();
    for (int p = 4; p < 8; p++) begin pol = 3'(p); step("R10"); end

    // R5 / R6: distinct, tied and partly tied occupancy
    iq = {4'd9, 4'd2, 4'd7, 4'd5}; lsq = {4'd1, 4'd8, 4'd3, 4'd3};
    pol = 3'd2; step("R5"); pol = 3'd3; step("R6");
    iq = {4'd6, 4'd6, 4'd6, 4'd6}; pol = 3'd2; step("R5");
    st[0] = 3'd2; lsq = {4'd3, 4'd8, 4'd3, 4'd0}; pol = 3'd3; step("R6");
    all_run();

    // R11: takes under other policies leave the order alone
    pol = 3'd2; take = 1'b1; step("R11"); pol = 3'd0; step("R11");
    pol = 3'd3; step("R11"); take = 1'b0; pol = 3'd1; step("R11");

    // R9: drop a thread, then bring it back at the tail
    act = 4'b1101; step("R9"); step("R9");
    act = 4'b1111; step("R9");
    take = 1'b1; for (int i = 0; i < 5; i++) step("R9_R4");
    take = 1'b0;

    // random mix against the reference list
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 3000; i++) begin
      for (int t = 0; t < N; t++) begin
        act[t] = ($urandom % 10) < 8;
        st[t]  = ($urandom % 2) ? 3'd0 : 3'($urandom % 8);
        iq[t]  = 4'($urandom % 16);
        lsq[t] = 4'($urandom % 4);
      end
      pol  = (($urandom % 8) == 0) ? 3'($urandom % 8) : 3'(($urandom % 3) + 1);
      take = $urandom % 2;
      step("R3_R5_R6_R9_random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule